// File: doc/BRIEF.md
# Multiplierless Shift-Based Band-Pass Filter

This block is a multichannel FIR band-pass filter for 16-bit two's-complement neural samples. Every coefficient is held as a signed power of two: a sign flag and a right-shift amount. Each tap therefore needs no multiplier. A tap optionally negates the sample and then shifts it right arithmetically. All channels are filtered side by side. They share one set of coefficients, and each keeps its own delay line.

A common pipeline strobe paces the block. When the strobe is seen, one new sample per channel is taken from the parallel input word and pushed into that channel's delay line. A short control sequence then forms the tap sum with guard bits, clamps it to 16 bits, and writes it to the per-channel output word. A one-clock `out_valid` pulse marks the new results. The coefficients are fixed at elaboration time by two parameters: a sign mask and a packed field of shift amounts.

The controller has three states. ST_IDLE waits for the strobe, and on a strobe it shifts the delay lines and moves to ST_SUM. ST_SUM captures every channel's accumulated tap sum and always moves to ST_WRITE. ST_WRITE stores the clamped results, raises `out_valid` for the following clock and always returns to ST_IDLE.

Top module: `bpf_shift_fir`

## Requirements
- R1: After a synchronous active-high reset, every delay-line entry and every output word is zero, and `out_valid` is low.
- R2: A tap whose sign flag is set contributes floor(-x / 2^s); otherwise it contributes floor(x / 2^s). Here x is the sample at that tap position and s is its shift amount. Tap i takes its sign from bit i of COEF_NEG and its shift from bits [i*SHW +: SHW] of COEF_SH. Tap 0 holds the newest sample.
- R3: Each output word equals the sum of all tap contributions over the channel's last TAPS accepted samples, with zeros standing in for samples not yet received.
- R4: A sum above 32767 is written as 32767.
- R5: A sum below -32768 is written as -32768.
- R6: `out_valid` is high for exactly one clock, in the clock that follows the third rising edge counted from the edge that sampled the accepted strobe.
- R7: A strobe that arrives while the controller is outside ST_IDLE is ignored. The ignored sample is never pushed into any delay line.
- R8: Channels are independent. Channel c reads `in_samples[c*16 +: 16]` and writes `out_samples[c*16 +: 16]`.
- R9: Output words change only in the cycle in which `out_valid` is raised, and they hold their values between results.
- R10: A sample of -32768 at a negated tap yields a positive contribution of 32768 / 2^s, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Pipeline strobe; accepts one sample per channel |
| in_samples | input | CH*W | Per-channel input samples, channel c at [c*W +: W] |
| out_samples | output | CH*W | Per-channel filtered outputs, channel c at [c*W +: W] |
| out_valid | output | 1 | One-clock pulse marking new output words |

## Verification
An accepted strobe is sampled at edge E0. The controller holds the sum at E1 and writes the outputs at E2, so results and `out_valid` are visible in the low phase after E2. The bench drives inputs and samples outputs on falling edges. It checks that `out_valid` is low after E0 and after E1, high with the new data after E2, and low again after E3. A reference delay line in the bench applies the coefficient arithmetic to impulses, full-scale runs for both saturation limits, a held strobe and a long pseudo-random sweep on two channels at once.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SUM   = 2'd1,
        ST_WRITE = 2'd2
    } fir_state_t;
endpackage

// File: rtl/bpf_ctrl.sv
module bpf_ctrl
    import bpf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic shift_en,
    output logic sum_en,
    output logic wr_en,
    output logic valid
);
    fir_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (strobe) state_nx = ST_SUM;
            ST_SUM:   state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        sum_en   = 1'b0;
        wr_en    = 1'b0;
        unique case (state)
            ST_IDLE:  shift_en = strobe;
            ST_SUM:   sum_en   = 1'b1;
            ST_WRITE: wr_en    = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) valid <= 1'b0;
        else     valid <= wr_en;
    end
endmodule

// File: rtl/bpf_tap.sv
module bpf_tap #(
    parameter int W   = 16,
    parameter int SHW = 4,
    parameter bit NEG = 1'b0,
    parameter logic [SHW-1:0] SH = '0
) (
    input  logic [W-1:0] x,
    output logic [W:0]   p
);
    logic signed [W:0] ext;
    logic signed [W:0] signed_x;

    // one guard bit so that negating the most negative sample cannot wrap
    always_comb begin
        ext = $signed({x[W-1], x});
        if (NEG) signed_x = (~ext) + 1'b1;
        else     signed_x = ext;
        p = signed_x >>> SH;
    end
endmodule

// File: rtl/bpf_chan.sv
module bpf_chan #(
    parameter int W    = 16,
    parameter int TAPS = 16,
    parameter int SHW  = 4,
    parameter logic [TAPS-1:0]     COEF_NEG = '0,
    parameter logic [TAPS*SHW-1:0] COEF_SH  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sum_en,
    input  logic         wr_en,
    input  logic [W-1:0] sample,
    output logic [W-1:0] result
);
    localparam int G  = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam int AW = W + 1 + G;

    logic [W-1:0]  dly  [TAPS];
    logic [W:0]    prod [TAPS];
    logic [AW-1:0] sum_c;
    logic [AW-1:0] acc;
    logic          fits;
    logic [W-1:0]  clamped;

    // delay line, newest sample at position 0
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) dly[i] <= '0;
        end else if (shift_en) begin
            dly[0] <= sample;
            for (int i = 1; i < TAPS; i++) dly[i] <= dly[i-1];
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        bpf_tap #(
            .W(W), .SHW(SHW),
            .NEG(COEF_NEG[t]),
            .SH(COEF_SH[t*SHW +: SHW])
        ) u_tap (
            .x(dly[t]),
            .p(prod[t])
        );
    end

    always_comb begin
        sum_c = '0;
        for (int i = 0; i < TAPS; i++)
            sum_c = sum_c + {{(AW-W-1){prod[i][W]}}, prod[i]};
    end

    always_ff @(posedge clk) begin
        if (rst)         acc <= '0;
        else if (sum_en) acc <= sum_c;
    end

    // the sum fits in W bits when all bits above W-1 copy the sign
    always_comb begin
        fits = (acc[AW-1:W-1] == '0) || (acc[AW-1:W-1] == '1);
        if (fits)            clamped = acc[W-1:0];
        else if (acc[AW-1])  clamped = {1'b1, {(W-1){1'b0}}};
        else                 clamped = {1'b0, {(W-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst)        result <= '0;
        else if (wr_en) result <= clamped;
    end
endmodule

// File: rtl/bpf_shift_fir.sv
module bpf_shift_fir #(
    parameter int CH   = 4,
    parameter int W    = 16,
    parameter int TAPS = 16,
    parameter int SHW  = 4,
    parameter logic [TAPS-1:0]     COEF_NEG = 16'b1100_0000_0000_0011,
    parameter logic [TAPS*SHW-1:0] COEF_SH  = 64'h5432_1000_0001_2345
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [CH*W-1:0] in_samples,
    output logic [CH*W-1:0] out_samples,
    output logic          out_valid
);
    logic shift_en, sum_en, wr_en;

    bpf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .strobe(strobe),
        .shift_en(shift_en), .sum_en(sum_en), .wr_en(wr_en),
        .valid(out_valid)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        bpf_chan #(
            .W(W), .TAPS(TAPS), .SHW(SHW),
            .COEF_NEG(COEF_NEG), .COEF_SH(COEF_SH)
        ) u_chan (
            .clk(clk), .rst(rst),
            .shift_en(shift_en), .sum_en(sum_en), .wr_en(wr_en),
            .sample(in_samples[c*W +: W]),
            .result(out_samples[c*W +: W])
        );
    end
endmodule

// File: rtl/bpf_shift_fir_chk.sv
module bpf_shift_fir_chk #(
    parameter int CH = 4,
    parameter int W  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            strobe,
    input logic [CH*W-1:0] out_samples,
    input logic            out_valid
);
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(strobe, 3));

    assert_busy_gap_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!$past(out_valid, 1) && !$past(out_valid, 2)));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_samples) |-> out_valid);
endmodule

bind bpf_shift_fir bpf_shift_fir_chk #(.CH(CH), .W(W)) u_chk (
    .clk(clk), .rst(rst), .strobe(strobe),
    .out_samples(out_samples), .out_valid(out_valid)
);

// File: tb/test_bpf_shift_fir.sv
module test_bpf_shift_fir;
    localparam int CH = 2, W = 16, TAPS = 4, SHW = 4;
    localparam logic [TAPS-1:0]     NEGS = 4'b0100;
    localparam logic [TAPS*SHW-1:0] SHS  = {4'd0, 4'd2, 4'd1, 4'd0};

    logic clk = 1'b0, rst = 1'b1, strobe = 1'b0;
    logic [CH*W-1:0] in_samples = '0;
    logic [CH*W-1:0] out_samples;
    logic out_valid;

    int total = 0, bad = 0;
    int hist [CH][TAPS];

    always #10 clk = ~clk;

    bpf_shift_fir #(.CH(CH), .W(W), .TAPS(TAPS), .SHW(SHW),
                    .COEF_NEG(NEGS), .COEF_SH(SHS)) i_bpf_shift_fir (
        .clk(clk), .rst(rst), .strobe(strobe), .in_samples(in_samples),
        .out_samples(out_samples), .out_valid(out_valid));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tapval(input int s, input int i);
        int v = NEGS[i] ? -s : s;
        return v >>> SHS[i*SHW +: SHW];
    endfunction

    function automatic int model(input int c);
        int s = 0;
        for (int i = 0; i < TAPS; i++) s += tapval(hist[c][i], i);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    function automatic int outw(input int c);
        return int'($signed(out_samples[c*W +: W]));
    endfunction

    // drive one accepted strobe; hold_extra keeps strobe high one more
    // cycle with other data (R7: must be ignored)
    task automatic run(input int a0, input int a1, input bit hold_extra, input string req);
        @(negedge clk);
        in_samples = {a1[W-1:0], a0[W-1:0]};
        strobe = 1'b1;
        for (int c = 0; c < CH; c++) begin
            for (int i = TAPS-1; i > 0; i--) hist[c][i] = hist[c][i-1];
        end
        hist[0][0] = int'($signed(a0[W-1:0]));
        hist[1][0] = int'($signed(a1[W-1:0]));
        @(negedge clk);                 // after E0
        if (hold_extra) in_samples = {16'h1234, 16'h7abc};
        else strobe = 1'b0;
        chk("R6", out_valid, 0);
        @(negedge clk);                 // after E1
        strobe = 1'b0;
        chk("R6", out_valid, 0);
        @(negedge clk);                 // after E2
        chk("R6", out_valid, 1);
        for (int c = 0; c < CH; c++) chk(req, outw(c), model(c));
        @(negedge clk);                 // after E3
        chk("R6", out_valid, 0);
    endtask

    initial begin
        #3000000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lf;
        int held0, held1;
        for (int c = 0; c < CH; c++)
            for (int i = 0; i < TAPS; i++) hist[c][i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", out_valid, 0);
        chk("R1", outw(0), 0);
        chk("R1", outw(1), 0);

        // R2 impulse through each tap, R8 different patterns per channel
        run(1001, -7, 0, "R2");
        run(0, 0, 0, "R2");
        run(0, 300, 0, "R8");
        run(0, 0, 0, "R2");
        run(0, 0, 0, "R3");
        // R10 most negative sample through the negated tap
        run(-32768, 0, 0, "R10");
        run(0, 0, 0, "R10");
        run(0, 0, 0, "R10");
        chk("R10", outw(0), 8192);
        // R4 positive saturation
        for (int k = 0; k < 4; k++) run(32767, 100, 0, "R4");
        chk("R4", outw(0), 32767);
        // R5 negative saturation
        for (int k = 0; k < 4; k++) run(-32768, -100, 0, "R5");
        chk("R5", outw(0), -32768);
        // R7 held strobe: second sample must not enter the delay line
        run(500, -500, 1, "R7");
        run(0, 0, 0, "R7");
        run(0, 0, 0, "R7");
        // R9 hold between results
        held0 = outw(0); held1 = outw(1);
        repeat (10) @(negedge clk);
        chk("R9", outw(0), held0);
        chk("R9", outw(1), held1);
        chk("R9", out_valid, 0);
        // R3 pseudo-random sweep on both channels
        lf = 32'h1ace;
        for (int k = 0; k < 400; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
            run(int'($signed(lf[15:0])), int'($signed(lf[31:16])), 0, "R3");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule